// File: doc/BRIEF.md
# First-Error Fault Capture Registers

This block sits beside a memory system and records diagnostic information about the first memory or paging fault that occurs. It keeps two independent captures. The range capture watches every physical access, flags any whose 24-bit address lies beyond the installed memory, and stores the failing address split across an address word and a status word. The status word also carries flags for a DMA source or an instruction fetch. The paging capture stores one packed word describing a page fault or protection violation: the table number, the page number, a fetch flag and a permission-miss flag.

Each capture freezes on the first fault it sees and ignores later faults until software releases it by reading the right register. The interrupt-cause pulses are raised for every fault, whether or not the capture was free to record it. Software reads all three words through one read port. The read data is a combinational view selected by `rd_sel`, and the `rd_en` strobe marks an actual read, which is the event that releases a lock.

Top module: `fault_status_regs`

## Requirements
- R1: An access is out of range when its address, masked to its low 24 bits, is greater than or equal to `MEM_WORDS` (default 524288). An in-range access raises no pulse and records nothing.
- R2: When the range capture is free, an out-of-range access is recorded on the next clock edge. The address word (rd_sel 0) holds address bits 15:0. The status word (rd_sel 1) holds address bits 23:16 in bits 7:0, `acc_dma` in bit 15 and `acc_fetch` in bit 14, and all other bits are 0.
- R3: Once recorded, the address and status words keep their values through any later out-of-range accesses until the lock is released.
- R4: A read with rd_sel 0 releases the range lock. A read with rd_sel 1 leaves it set.
- R5: When the paging capture is free, a paging fault is recorded as the paging word (rd_sel 2). `pg_table` goes in bits 7:6, `pg_page` in bits 5:0 and `pg_fetch` in bit 14. Bit 15 is the permission-miss flag: it is 1 for `pg_kind` 0 (page absent) and 1 (permit bit missing), and 0 for `pg_kind` 2 or 3 (ring violation).
- R6: The paging word keeps its value through later paging faults until a read with rd_sel 2 releases its lock.
- R7: `oor_irq` is high for exactly the cycle after each out-of-range access, whether or not the range capture was locked.
- R8: In the cycle after a paging fault, `pf_irq` pulses for `pg_kind` 0, and `pv_irq` pulses for `pg_kind` 1, 2 or 3. Both pulses are independent of the lock.
- R9: Reset clears all three words, both locks and all pulses, and the first fault after reset is recorded.
- R10: If a releasing read and a new fault reach a locked capture in the same cycle, the new fault is recorded and the capture stays locked. The read returns the old value.
- R11: `rd_data` shows the word chosen by `rd_sel` in the same cycle. rd_sel 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Physical access strobe |
| acc_addr | input | 32 | Physical access address (low 24 bits used) |
| acc_dma | input | 1 | Access comes from DMA |
| acc_fetch | input | 1 | Access is an instruction fetch |
| pg_valid | input | 1 | Paging fault strobe |
| pg_table | input | 2 | Page table number of the fault |
| pg_page | input | 6 | Page number of the fault |
| pg_fetch | input | 1 | Faulting access was a fetch |
| pg_kind | input | 2 | 0 absent, 1 permit missing, 2/3 ring violation |
| rd_en | input | 1 | Register read strobe (releases locks) |
| rd_sel | input | 2 | 0 address, 1 status, 2 paging, 3 none |
| rd_data | output | 16 | Selected register value |
| oor_irq | output | 1 | Out-of-range interrupt-cause pulse |
| pf_irq | output | 1 | Page-fault interrupt-cause pulse |
| pv_irq | output | 1 | Protection-violation interrupt-cause pulse |

## Verification
Directed sequences use addresses on either side of the memory limit, some with garbage above bit 23, to separate correct masking and a correct comparison bound from off-by-one and unmasked compares. Streams of faults are applied around reads of each register. These show which read releases which lock, and that pulses keep coming while a capture is frozen. A same-cycle read and fault tells capture priority apart from release priority. A long pseudo-random mix of accesses, paging faults of every kind and reads is checked each cycle against a behavioural model. That run covers interleavings the directed cases miss.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W        = 16;
  localparam int ST_DMA_BIT   = 15;
  localparam int ST_FETCH_BIT = 14;
  localparam int PG_MISS_BIT  = 15;
  localparam int PG_FETCH_BIT = 14;

  typedef enum logic [1:0] {
    PGK_ABSENT  = 2'd0,
    PGK_NOPERM  = 2'd1,
    PGK_RING    = 2'd2,
    PGK_RING_X  = 2'd3
  } pg_kind_e;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PAGE = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/fsr_lock_reg.sv
module fsr_lock_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_req,
  input  logic [W-1:0] cap_data,
  input  logic         unlock,
  output logic [W-1:0] q,
  output logic         locked
);
  logic [W-1:0] q_d;
  logic         lock_d;
  logic         take;

  // capture wins over a same-cycle release
  assign take = cap_req && (!locked || unlock);

  always_comb begin
    q_d    = q;
    lock_d = locked;
    if (take) begin
      q_d    = cap_data;
      lock_d = 1'b1;
    end else if (unlock) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      locked <= 1'b0;
    end else begin
      if (take) q <= q_d;
      locked <= lock_d;
    end
  end

  assert_hold_while_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !unlock) |=> $stable(q));

  assert_free_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && !locked) |=> (locked && q == $past(cap_data)));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !cap_req) |=> !locked);
endmodule

// File: rtl/fsr_range_check.sv
module fsr_range_check
  import fsr_pkg::*;
#(
  parameter int IN_AW     = 32,
  parameter int PA_W      = 24,
  parameter int MEM_WORDS = 524288
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [IN_AW-1:0]   acc_addr,
  input  logic               acc_dma,
  input  logic               acc_fetch,
  output logic               err,
  output logic [2*REG_W-1:0] cap_word,
  output logic               irq_q
);
  localparam int HI_W = PA_W - REG_W;
  localparam logic [IN_AW-1:0] PA_MASK = IN_AW'((64'd1 << PA_W) - 64'd1);
  localparam logic [IN_AW-1:0] LIMIT   = IN_AW'(MEM_WORDS);

  logic [IN_AW-1:0] masked;
  logic [REG_W-1:0] stat_w;
  logic             irq_d;

  assign masked = acc_addr & PA_MASK;
  assign err    = acc_valid && (masked >= LIMIT);

  always_comb begin
    stat_w               = '0;
    stat_w[HI_W-1:0]     = masked[PA_W-1:REG_W];
    stat_w[ST_DMA_BIT]   = acc_dma;
    stat_w[ST_FETCH_BIT] = acc_fetch;
  end

  assign cap_word = {stat_w, masked[REG_W-1:0]};
  assign irq_d    = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assert_pulse_follows_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(acc_valid));
endmodule

// File: rtl/fsr_page_encode.sv
module fsr_page_encode
  import fsr_pkg::*;
#(
  parameter int PT_W = 2,
  parameter int PG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_valid,
  input  logic [PT_W-1:0]  pg_table,
  input  logic [PG_W-1:0]  pg_page,
  input  logic             pg_fetch,
  input  logic [1:0]       pg_kind,
  output logic [REG_W-1:0] word,
  output logic             pf_q,
  output logic             pv_q
);
  pg_kind_e kind;
  logic     miss;
  logic     pf_d, pv_d;

  assign kind = pg_kind_e'(pg_kind);
  assign miss = (kind == PGK_ABSENT) || (kind == PGK_NOPERM);

  always_comb begin
    word                        = '0;
    word[PG_W+PT_W-1:PG_W]      = pg_table;
    word[PG_W-1:0]              = pg_page;
    word[PG_FETCH_BIT]          = pg_fetch;
    word[PG_MISS_BIT]           = miss;
  end

  assign pf_d = pg_valid && (kind == PGK_ABSENT);
  assign pv_d = pg_valid && (kind != PGK_ABSENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      pv_q <= 1'b0;
    end else begin
      pf_q <= pf_d;
      pv_q <= pv_d;
    end
  end

  assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_q && pv_q));
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
  import fsr_pkg::*;
#(
  parameter int IN_AW     = 32,
  parameter int PA_W      = 24,
  parameter int MEM_WORDS = 524288,
  parameter int PT_W      = 2,
  parameter int PG_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IN_AW-1:0] acc_addr,
  input  logic             acc_dma,
  input  logic             acc_fetch,
  input  logic             pg_valid,
  input  logic [PT_W-1:0]  pg_table,
  input  logic [PG_W-1:0]  pg_page,
  input  logic             pg_fetch,
  input  logic [1:0]       pg_kind,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [15:0]      rd_data,
  output logic             oor_irq,
  output logic             pf_irq,
  output logic             pv_irq
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               range_err;
  logic [2*REG_W-1:0] range_word;
  logic [2*REG_W-1:0] pair_q;
  logic               pair_locked;
  logic [REG_W-1:0]   page_word;
  logic [REG_W-1:0]   page_q;
  logic               page_locked;
  logic               rel_pair, rel_page;
  rd_sel_e            sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign sel      = rd_sel_e'(rd_sel);
  assign rel_pair = rd_en && (sel == SEL_ADDR);
  assign rel_page = rd_en && (sel == SEL_PAGE);

  fsr_range_check #(
    .IN_AW(IN_AW), .PA_W(PA_W), .MEM_WORDS(MEM_WORDS)
  ) u_range (
    .clk(clk), .rst_n(rst_int_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_dma(acc_dma), .acc_fetch(acc_fetch),
    .err(range_err), .cap_word(range_word), .irq_q(oor_irq)
  );

  fsr_lock_reg #(.W(2*REG_W)) u_pair (
    .clk(clk), .rst_n(rst_int_n),
    .cap_req(range_err), .cap_data(range_word), .unlock(rel_pair),
    .q(pair_q), .locked(pair_locked)
  );

  fsr_page_encode #(.PT_W(PT_W), .PG_W(PG_W)) u_page (
    .clk(clk), .rst_n(rst_int_n),
    .pg_valid(pg_valid), .pg_table(pg_table), .pg_page(pg_page),
    .pg_fetch(pg_fetch), .pg_kind(pg_kind),
    .word(page_word), .pf_q(pf_irq), .pv_q(pv_irq)
  );

  fsr_lock_reg #(.W(REG_W)) u_pglk (
    .clk(clk), .rst_n(rst_int_n),
    .cap_req(pg_valid), .cap_data(page_word), .unlock(rel_page),
    .q(page_q), .locked(page_locked)
  );

  always_comb begin
    case (sel)
      SEL_ADDR: rd_data = pair_q[REG_W-1:0];
      SEL_STAT: rd_data = pair_q[2*REG_W-1:REG_W];
      SEL_PAGE: rd_data = page_q;
      default:  rd_data = '0;
    endcase
  end

  assert_range_pulse_locks_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    oor_irq |-> pair_locked);

  assert_page_pulse_locks_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pf_irq || pv_irq) |-> page_locked);

  assert_status_read_keeps_lock_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pair_locked && rd_en && sel == SEL_STAT) |=> pair_locked);
endmodule

// File: tb/fault_status_regs_tb.sv
module fault_status_regs_tb;
  localparam int MEM = 524288;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_dma, acc_fetch;
  logic [31:0] acc_addr;
  logic        pg_valid, pg_fetch;
  logic [1:0]  pg_table, pg_kind;
  logic [5:0]  pg_page;
  logic        rd_en;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic        oor_irq, pf_irq, pv_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_addr, m_stat, m_pg;
  bit lk_a, lk_p, m_oor, m_pf, m_pv;

  always #10 clk = ~clk;

  fault_status_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_dma(acc_dma), .acc_fetch(acc_fetch),
    .pg_valid(pg_valid), .pg_table(pg_table), .pg_page(pg_page),
    .pg_fetch(pg_fetch), .pg_kind(pg_kind),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .oor_irq(oor_irq), .pf_irq(pf_irq), .pv_irq(pv_irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_stat = 0; m_pg = 0;
      lk_a = 0; lk_p = 0; m_oor = 0; m_pf = 0; m_pv = 0;
    end else begin
      int a;
      bit oor, rda, rdp;
      a   = int'(acc_addr & 32'h00FF_FFFF);
      oor = acc_valid && (a >= MEM);
      rda = rd_en && rd_sel == 2'd0;
      rdp = rd_en && rd_sel == 2'd2;
      if (oor && (!lk_a || rda)) begin
        m_addr = a % 65536;
        m_stat = (a / 65536) + (acc_dma ? 32768 : 0) + (acc_fetch ? 16384 : 0);
        lk_a = 1;
      end else if (rda) lk_a = 0;
      if (pg_valid && (!lk_p || rdp)) begin
        m_pg = int'(pg_table) * 64 + int'(pg_page) + (pg_fetch ? 16384 : 0)
             + ((pg_kind < 2) ? 32768 : 0);
        lk_p = 1;
      end else if (rdp) lk_p = 0;
      m_oor = oor;
      m_pf  = pg_valid && pg_kind == 2'd0;
      m_pv  = pg_valid && pg_kind != 2'd0;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R7 oor_irq", int'(oor_irq), int'(m_oor));
      chk("R8 pf_irq", int'(pf_irq), int'(m_pf));
      chk("R8 pv_irq", int'(pv_irq), int'(m_pv));
      case (rd_sel)
        2'd0: chk("R2 R3 R4 R10 addr word", int'(rd_data), m_addr);
        2'd1: chk("R2 R3 status word", int'(rd_data), m_stat);
        2'd2: chk("R5 R6 paging word", int'(rd_data), m_pg);
        default: chk("R11 empty select", int'(rd_data), 0);
      endcase
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    acc_valid = 0; acc_dma = 0; acc_fetch = 0; acc_addr = '0;
    pg_valid = 0; pg_fetch = 0; pg_table = '0; pg_page = '0; pg_kind = '0;
    rd_en = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic d, input logic f);
    acc_valid = 1; acc_addr = a; acc_dma = d; acc_fetch = f;
  endtask

  task automatic pfault(input logic [1:0] t, input logic [5:0] p, input logic f, input logic [1:0] k);
    pg_valid = 1; pg_table = t; pg_page = p; pg_fetch = f; pg_kind = k;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rd_sel = 2'd0; idle();
    repeat (3) tick();
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #1;
      chk("R9 reset value", int'(rd_data), 0);
    end
    rst_n = 1;
    repeat (4) tick();

    // R1: boundary and masking
    access(32'hFF07_FFFF, 0, 0); tick(); idle();
    chk("R1 in range no pulse", int'(oor_irq), 0);
    access(32'h0008_0000, 1, 0); tick(); idle(); rd_sel = 2'd0; #1;
    chk("R1 limit is error", int'(oor_irq), 1);
    chk("R2 addr low", int'(rd_data), 32'h0000);
    rd_sel = 2'd1; #1;
    chk("R2 status dma", int'(rd_data), 32'h8008);
    // R3: second error ignored, pulse still raised (R7)
    access(32'hAAAB_CDEF, 0, 1); tick(); idle(); #1;
    chk("R7 pulse while locked", int'(oor_irq), 1);
    chk("R3 status held", int'(rd_data), 32'h8008);
    // R4: status read keeps lock
    rd_en = 1; rd_sel = 2'd1; tick(); idle();
    access(32'h00AB_CDEF, 0, 1); tick(); idle(); rd_sel = 2'd0; #1;
    chk("R4 status read keeps lock", int'(rd_data), 32'h0000);
    // R4: addr read releases
    rd_en = 1; tick(); idle();
    access(32'h00AB_CDEF, 0, 1); tick(); idle(); #1;
    chk("R4 addr read releases", int'(rd_data), 32'hCDEF);
    rd_sel = 2'd1; #1;
    chk("R2 status fetch", int'(rd_data), 32'h40AB);
    // R10: release and capture in same cycle
    rd_sel = 2'd0; rd_en = 1; access(32'h0012_3456, 0, 0); #1;
    chk("R10 read returns old", int'(rd_data), 32'hCDEF);
    tick(); idle(); #1;
    chk("R10 new captured", int'(rd_data), 32'h3456);
    access(32'h0099_0000, 0, 0); tick(); idle(); #1;
    chk("R10 stays locked", int'(rd_data), 32'h3456);

    // R5 / R6 / R8 paging
    rd_sel = 2'd2;
    pfault(2'd3, 6'd5, 1, 2'd2); tick(); idle(); #1;
    chk("R5 ring violation no miss", int'(rd_data), 32'h40C5);
    chk("R8 ring gives pv", int'(pv_irq), 1);
    pfault(2'd1, 6'd9, 0, 2'd0); tick(); idle(); #1;
    chk("R8 absent gives pf", int'(pf_irq), 1);
    chk("R6 paging held", int'(rd_data), 32'h40C5);
    rd_en = 1; tick(); idle();
    pfault(2'd1, 6'd9, 0, 2'd0); tick(); idle(); #1;
    chk("R5 absent sets miss", int'(rd_data), 32'h8049);
    rd_en = 1; tick(); idle();
    pfault(2'd2, 6'd63, 1, 2'd1); tick(); idle(); #1;
    chk("R5 noperm sets miss", int'(rd_data), 32'hC0BF);
    rd_sel = 2'd3; #1;
    chk("R11 select 3 zero", int'(rd_data), 0);

    // R9: reset with both locks set, then fresh capture
    rst_n = 0; tick();
    rd_sel = 2'd2; #1;
    chk("R9 paging cleared", int'(rd_data), 0);
    rst_n = 1; repeat (4) tick();
    pfault(2'd0, 6'd1, 0, 2'd3); access(32'h00F0_0001, 0, 0); tick(); idle(); #1;
    chk("R9 capture after reset", int'(rd_data), 32'h0001);
    rd_sel = 2'd0; #1;
    chk("R9 range after reset", int'(rd_data), 32'h0001);

    // mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      idle();
      if (r % 3 == 0) access(((r % 2) != 0) ? $urandom : 32'($urandom_range(0, MEM + 2000)),
                             1'($urandom), 1'($urandom));
      if (r % 5 == 0) pfault(2'($urandom), 6'($urandom), 1'($urandom), 2'($urandom));
      if (r % 4 == 1) rd_en = 1;
      rd_sel = 2'($urandom);
      tick();
    end
    idle(); tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule